// File: doc/BRIEF.md
# Four-Cycle Period Meter

This block measures the period of a clean square wave by counting reference ticks over four consecutive input cycles. The measured signal is asynchronous. It is brought into the system clock domain, and the block then works on its rising edges only. A three-bit phase counter advances on every rising edge, and one full sequence takes eight edges. The first edge clears the tick counter and starts it. The fifth edge stops the counter and loads its value into a holding register. The sixth edge clears the counter. The seventh and eighth edges are idle.

The reference tick is a one-clock enable that a prescaler makes from the system clock. The prescaler period is set at run time. A slow reader reads the published result. The result is forced to zero while an update is in progress, and a measurement is never published as zero, so a zero always means "not valid now". The reader can also test the busy flag. A one-clock strobe marks each capture. An overflow flag reports a window whose count hit the saturation limit.

Top module: `period_meter`

## Requirements
- R1: While reset is asserted and right after it, result is 0, busy is 1, valid is 0 and overflow is 0.
- R2: With a tick every clock, a window of four input periods of P clocks publishes 4*P-1. The tick that lands in the same clock as the start edge is not counted, and neither is the tick that lands with the capture edge.
- R3: With prescaler setting D, one tick comes every D+1 clocks, so the published count is floor or ceil of (4*P-1)/(D+1).
- R4: The count saturates at 2^CNT_W-1 (255 by default). overflow is 1 after a window in which a tick arrived while the count was already at the limit. A window that ends exactly at the limit leaves overflow at 0. Each capture updates overflow.
- R5: busy rises at the capture (5th rising edge of the sequence) and falls at the clear (6th edge). result reads 0 whenever busy is 1.
- R6: valid is high for exactly one clock per sequence, in the same clock that busy rises.
- R7: The sequence repeats every 8 rising edges, and the 9th edge starts the next window. While busy is 0, result stays unchanged across input edges until the next capture.
- R8: A window with no counted ticks publishes 1, so 0 is never a published measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_div | input | PRESC_W | Prescaler setting; one tick every presc_div+1 clocks |
| sig_in | input | 1 | Asynchronous square wave to measure |
| result | output | CNT_W | Ticks over four periods; 0 while not valid |
| busy | output | 1 | High while an update is in progress |
| valid | output | 1 | One-clock strobe when a new count is captured |
| overflow | output | 1 | The last captured window saturated |

## Verification
A reference tick can fall in the same clock as the start edge or the capture edge, and there the tick competes with the phase action. Setting the prescaler to zero puts a tick in every clock, so both collisions happen in every window. The published 4*P-1 then shows that the edge action took priority and that neither boundary tick was counted. Saturation meets the capture edge in the same way: a window of exactly 64 periods' worth of ticks must give 255 with no overflow, and one more tick must set overflow.

// File: rtl/pm_pkg.sv
package pm_pkg;
   // Edge index within the eight-edge sequence at which each action fires.
   localparam int PH_W = 3;
   typedef enum logic [PH_W-1:0] {
      PH_START = 3'd0,
      PH_RUN1  = 3'd1,
      PH_RUN2  = 3'd2,
      PH_RUN3  = 3'd3,
      PH_CAPT  = 3'd4,
      PH_CLR   = 3'd5,
      PH_IDLE1 = 3'd6,
      PH_IDLE2 = 3'd7
   } phase_t;

   typedef struct packed {
      logic start;
      logic capture;
      logic clear;
   } strobe_t;
endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], din};
   end

   // pipe[STAGES-1] is the last synchroniser flop, pipe[STAGES] its delayed copy
   assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/pm_prescaler.sv
module pm_prescaler #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] div,
   output logic         tick
);
   generate
      if (W < 1) begin : g_bad
         $error("pm_prescaler: W must be positive");
      end
   endgenerate

   logic [W-1:0] pc;

   assign tick = (pc >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc <= '0;
      else if (tick) pc <= '0;
      else           pc <= pc + 1'b1;
   end
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
   import pm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    edge_i,
   output strobe_t stb
);
   phase_t ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ph <= PH_START;
      else if (edge_i) ph <= phase_t'(ph + 1'b1);
   end

   always_comb begin
      stb.start   = edge_i && (ph == PH_START);
      stb.capture = edge_i && (ph == PH_CAPT);
      stb.clear   = edge_i && (ph == PH_CLR);
   end
endmodule

// File: rtl/pm_tick_counter.sv
module pm_tick_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         stop,
   input  logic         clear,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         sat
);
   localparam logic [W-1:0] CMAX = {W{1'b1}};

   logic run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
         sat <= 1'b0;
      end else if (start) begin
         cnt <= '0;
         run <= 1'b1;
         sat <= 1'b0;
      end else if (stop) begin
         run <= 1'b0;
      end else if (clear) begin
         cnt <= '0;
      end else if (run && tick) begin
         if (cnt == CMAX) sat <= 1'b1;
         else             cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/period_meter.sv
module period_meter
   import pm_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PRESC_W     = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit ZERO_FLOOR  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRESC_W-1:0] presc_div,
   input  logic               sig_in,
   output logic [CNT_W-1:0]   result,
   output logic               busy,
   output logic               valid,
   output logic               overflow
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("period_meter: CNT_W must be at least 2");
      end
   endgenerate

   logic             rise;
   logic             tick;
   strobe_t          stb;
   logic [CNT_W-1:0] cnt;
   logic             sat;
   logic [CNT_W-1:0] cap_val;
   logic [CNT_W-1:0] hold;

   pm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(rise));

   pm_prescaler #(.W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .div(presc_div), .tick(tick));

   pm_sequencer u_seq (
      .clk(clk), .rst_n(rst_n), .edge_i(rise), .stb(stb));

   pm_tick_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(stb.start), .stop(stb.capture),
      .clear(stb.clear), .tick(tick), .cnt(cnt), .sat(sat));

   generate
      if (ZERO_FLOOR) begin : g_floor
         assign cap_val = (cnt == '0) ? ONE : cnt;
      end else begin : g_raw
         assign cap_val = cnt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold     <= '0;
         busy     <= 1'b1;
         valid    <= 1'b0;
         overflow <= 1'b0;
      end else begin
         valid <= stb.capture;
         if (stb.capture) begin
            hold     <= cap_val;
            busy     <= 1'b1;
            overflow <= sat;
         end else if (stb.clear) begin
            busy <= 1'b0;
         end
      end
   end

   assign result = hold & {CNT_W{~busy}};
endmodule

// File: rtl/pm_chk.sv
module pm_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] result,
   input logic             busy,
   input logic             valid,
   input logic             overflow
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   // R5
   busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (result == '0));

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R6
   valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> busy);

   // R8
   nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (result != '0));

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (busy || result == CMAX));

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(result));
endmodule

bind period_meter pm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .result(result), .busy(busy),
   .valid(valid), .overflow(overflow));

// File: tb/period_meter_tb.sv
module period_meter_tb;
   localparam int CNT_W   = 8;
   localparam int PRESC_W = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [PRESC_W-1:0] presc_div = '0;
   logic               sig_in = 1'b0;
   logic [CNT_W-1:0]   result;
   logic               busy;
   logic               valid;
   logic               overflow;

   int n_checks = 0;
   int n_fail   = 0;
   int valid_seen = 0;
   int cycles = 0;
   logic [CNT_W-1:0] prev_result = '0;

   always #2.5 clk = ~clk;

   period_meter #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .presc_div(presc_div), .sig_in(sig_in),
      .result(result), .busy(busy), .valid(valid), .overflow(overflow));

   always @(negedge clk) begin
      cycles++;
      if (valid) valid_seen++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reset_dut(input int div);
      rst_n = 1'b0;
      sig_in = 1'b0;
      presc_div = PRESC_W'(div);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      prev_result = '0;
   endtask

   // Drives one eight-edge sequence of period p and checks it.
   task automatic run_window(input int p, input int lo, input int hi,
                             input bit exp_ovf, input string req);
      valid_seen = 0;
      for (int k = 0; k < 8; k++) begin
         for (int c = 0; c < p; c++) begin
            sig_in = (c < p / 2);
            @(negedge clk);
            if (c == 6 && k == 2)
               chk(result == prev_result, "R7 hold before capture", result, prev_result);
            if (c == 6 && k == 4) begin
               chk(busy == 1'b1, "R5 busy after capture", busy, 1);
               chk(result == '0, "R5 masked while busy", result, 0);
               chk(valid_seen == 1, "R6 valid at capture", valid_seen, 1);
            end
            if (c == 6 && k == 5) begin
               chk(busy == 1'b0, "R5 busy cleared", busy, 0);
               chk(result >= lo && result <= hi, req, result, lo);
               chk(overflow == exp_ovf, "R4 overflow flag", overflow, exp_ovf);
            end
            if (c == 6 && k == 7)
               chk(result >= lo && result <= hi, "R7 result held idle", result, lo);
         end
      end
      chk(valid_seen == 1, "R6 one valid per sequence", valid_seen, 1);
      prev_result = result;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(result == '0, "R1 result", result, 0);
      chk(busy == 1'b1, "R1 busy", busy, 1);
      chk(valid == 1'b0, "R1 valid", valid, 0);
      chk(overflow == 1'b0, "R1 overflow", overflow, 0);
      reset_dut(0);
      chk(busy == 1'b1 && result == '0, "R1 after release", result, 0);
   endtask

   task automatic t_basic;
      reset_dut(0);
      run_window(10, 39, 39, 1'b0, "R2 count P=10");
      run_window(20, 79, 79, 1'b0, "R2 R7 next window P=20");
   endtask

   task automatic t_saturation;
      reset_dut(0);
      run_window(64, 255, 255, 1'b0, "R4 exact limit");
      run_window(65, 255, 255, 1'b1, "R4 saturated");
      run_window(12, 47, 47, 1'b0, "R4 overflow cleared");
   endtask

   task automatic t_prescaler;
      reset_dut(4);
      run_window(25, 19, 20, 1'b0, "R3 div=4 P=25");
      presc_div = 16'd3;
      run_window(16, 15, 16, 1'b0, "R3 div=3 P=16");
   endtask

   task automatic t_floor;
      reset_dut(1000);
      run_window(10, 1, 1, 1'b0, "R8 zero-tick window");
   endtask

   initial begin
      t_reset();
      t_basic();
      t_saturation();
      t_prescaler();
      t_floor();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule